// File: doc/BRIEF.md
# Chained Receive Descriptor Engine

This engine moves received frame bytes into memory buffers that software hands it through a list of receive descriptors. Each descriptor occupies four consecutive 32-bit words in shared memory: status at offset 0, control at offset 4, buffer address at offset 8 and the address of the next descriptor at offset 12. The engine reads a descriptor and checks that the engine owns it. It then packs the incoming byte stream into 32-bit words with byte enables and stores them in the buffer. After the last data write has been accepted, it writes back a status word and moves on to the next descriptor.

Software gives a descriptor to the engine by setting the ownership bit. It learns that a frame has arrived when that bit has been cleared. If the engine finds a descriptor that software still holds, it parks and stays idle until a poll-demand strobe tells it to read the same descriptor again. The list base address is taken from an input when reception is enabled. Reception can only be switched off while the engine is parked or between descriptors. Every descriptor holds exactly one frame, so the first-segment and last-segment flags are both set on every status write-back.

Top module: `rx_desc_engine`

## Requirements
- R1: While reset is held, and while `rx_enable` is low after reset, the block issues no memory request and keeps `fr_ready` low.
- R2: When `rx_enable` rises, the block loads `list_base` as the current descriptor address. It then reads the four descriptor words in the order +0, +4, +8, +12.
- R3: If bit 31 (ownership) of the status word it reads is 0, the block parks. It makes no memory request and keeps `fr_ready` low until `poll_demand` is seen. On `poll_demand` it reads the status word of the same descriptor again.
- R4: Frame byte k is written to buffer address + (k with the low two bits cleared), in byte lane k mod 4 (little-endian). Only the lanes actually filled are enabled, and a trailing partial word is written with just its filled lanes enabled.
- R5: Bytes at positions at or beyond the buffer size (control bits 10:0) are not written, and the frame's status then has bit 15 (error summary) set. A buffer size of 0 writes no data at all.
- R6: The status write-back goes to descriptor offset 0 and is issued only after every data write of the frame has been accepted. It carries bit 31 = 0, bit 30 = 1, bit 8 = 1, and bits 29:16 = the number of bytes delivered, FCS included. Bit 15 is set when `fr_err` was high with the last byte or when the frame was truncated. All other bits are 0.
- R7: After the write-back, the next descriptor address depends on the control word. If bit 24 is set, it is the next-pointer word. Otherwise, if bit 25 is set, it is `list_base`. Otherwise it is the current address + 16. Bit 24 takes priority over bit 25.
- R8: A memory request that is not granted is held on the next cycle with the same address and direction.
- R9: A `poll_demand` pulse that arrives while the block is not parked has no effect. After such a frame, the block makes exactly one descriptor read before it parks again.
- R10: If `rx_enable` is low while the block is parked, the block turns off and ignores `poll_demand`. When it is enabled again, it starts from the current `list_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Reception on/off |
| list_base | input | AW | Address of the first descriptor |
| poll_demand | input | 1 | Strobe that restarts a parked engine |
| fr_valid | input | 1 | Frame byte valid |
| fr_data | input | 8 | Frame byte |
| fr_last | input | 1 | Marks the final byte of the frame |
| fr_err | input | 1 | Receive error, sampled with the final byte |
| fr_ready | output | 1 | Frame byte accepted when high together with fr_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a truncated frame whose last kept bytes form a partial word. In that case a trailing write with only some lanes enabled must still go out after the buffer limit is reached, and before the status word. The stimulus reaches it by giving descriptors buffer sizes that are not multiples of four and sending frames longer than the buffer. It also throttles the grant so that a write is still waiting while the discarded bytes drain. The stimulus also pulses poll-demand during reception and drops enable while the engine is parked. It then counts descriptor reads to show that neither event disturbs the descriptor walk.

// File: rtl/rxd_pkg.sv
// Package: shared state type and descriptor field positions for the
// receive descriptor engine. Assumes 32-bit descriptor words.
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_PARK,
        ST_RECV,
        ST_WB
    } rxd_state_e;

    localparam int OWN_BIT    = 31;
    localparam int FIRST_BIT  = 30;
    localparam int ERR_BIT    = 15;
    localparam int LAST_BIT   = 8;
    localparam int LEN_LSB    = 16;
    localparam int CHAIN_BIT  = 24;
    localparam int EOR_BIT    = 25;
    localparam int DESC_BYTES = 16;
    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/rxd_packer.sv
// Module: rxd_packer
// Packs a byte stream into little-endian 32-bit words with byte enables,
// bounded by the descriptor's buffer size. It counts every delivered byte
// (FCS included) and records truncation and input error.
// Assumes: the buffer address is word aligned; wr_ack is only taken while
// wr_valid is high; clr is pulsed before each frame.
module rxd_packer #(
    parameter int BSZ_W = 11,
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [BSZ_W-1:0] buf_size,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_err,
    output logic             in_ready,
    output logic             wr_valid,
    output logic [BSZ_W:0]   wr_off,
    output logic [31:0]      wr_data,
    output logic [3:0]       wr_be,
    input  logic             wr_ack,
    output logic             done,
    output logic [LEN_W-1:0] frame_len,
    output logic             frame_bad
);

    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [BSZ_W:0]   stored_q;
    logic [BSZ_W:0]   wptr_q;
    logic [31:0]      word_q;
    logic [3:0]       be_q;
    logic             pend_q;
    logic             fin_q;
    logic             trunc_q;
    logic             err_q;
    logic [LEN_W-1:0] len_q;
    logic             take;
    logic             fits;
    logic [1:0]       lane;

    // Handshake and placement decode for the current byte.
    always_comb begin
        in_ready = active && !pend_q && !fin_q;
        take     = in_valid && in_ready;
        fits     = stored_q < {1'b0, buf_size};
        lane     = stored_q[1:0];
    end

    // Byte placement, word flush, length and flag tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stored_q <= '0;
            wptr_q   <= '0;
            word_q   <= '0;
            be_q     <= '0;
            pend_q   <= 1'b0;
            fin_q    <= 1'b0;
            trunc_q  <= 1'b0;
            err_q    <= 1'b0;
            len_q    <= '0;
        end else begin
            if (pend_q && wr_ack) begin
                pend_q <= 1'b0;
                be_q   <= '0;
                word_q <= '0;
                wptr_q <= wptr_q + (BSZ_W+1)'(4);
            end
            if (take) begin
                if (len_q != LEN_MAX) begin
                    len_q <= len_q + 1'b1;
                end
                if (fits) begin
                    word_q[{lane, 3'b000} +: 8] <= in_data;
                    be_q[lane]                  <= 1'b1;
                    stored_q                    <= stored_q + 1'b1;
                    if (lane == 2'd3 || in_last) begin
                        pend_q <= 1'b1;
                    end
                end else begin
                    trunc_q <= 1'b1;
                    if (in_last && be_q != 4'b0000) begin
                        pend_q <= 1'b1;
                    end
                end
                if (in_last) begin
                    fin_q <= 1'b1;
                    err_q <= in_err;
                end
            end
        end
    end

    // Outputs toward the memory mux and the status composer.
    always_comb begin
        wr_valid  = pend_q;
        wr_off    = wptr_q;
        wr_data   = word_q;
        wr_be     = be_q;
        done      = fin_q && !pend_q;
        frame_len = len_q;
        frame_bad = trunc_q || err_q;
    end

    // R5: a data write never lands at or past the buffer size.
    p_write_inside_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_off < {1'b0, buf_size}));

    // R4: every flushed word carries at least one enabled lane.
    p_flush_has_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> (be_q != 4'b0000));

    // R6: a final byte that fell outside the buffer with no partial word
    // finishes the frame on the next cycle.
    p_drop_last_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_last && !fits && be_q == 4'b0000 && !clr) |=> done);

endmodule

// File: rtl/rxd_status_fmt.sv
// Module: rxd_status_fmt
// Builds the status write-back word. Ownership is returned to software,
// first and last flags are both set (one frame per descriptor), and the
// length and error summary come from the packer.
// Assumes: LEN_W fits between LEN_LSB and the first-segment bit.
module rxd_status_fmt #(
    parameter int LEN_W = 14
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             frame_bad,
    output logic [31:0]      status_word
);
    import rxd_pkg::*;

    // Pure field placement; every bit not named stays zero.
    always_comb begin
        status_word                      = '0;
        status_word[OWN_BIT]             = 1'b0;
        status_word[FIRST_BIT]           = 1'b1;
        status_word[LAST_BIT]            = 1'b1;
        status_word[ERR_BIT]             = frame_bad;
        status_word[LEN_LSB +: LEN_W]    = frame_len;
    end

endmodule

// File: rtl/rxd_next_sel.sv
// Module: rxd_next_sel
// Chooses the address of the following descriptor: the chain pointer when
// chaining is requested, the list base at end of ring, otherwise the next
// contiguous descriptor slot.
// Assumes: descriptors are DESC_BYTES apart when not chained.
module rxd_next_sel #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] chain_addr,
    input  logic          chain_en,
    input  logic          ring_end,
    output logic [AW-1:0] next_addr
);
    import rxd_pkg::*;

    // Chaining has priority over the end-of-ring mark.
    always_comb begin
        if (chain_en) begin
            next_addr = chain_addr;
        end else if (ring_end) begin
            next_addr = base_addr;
        end else begin
            next_addr = cur_addr + AW'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/rx_desc_engine.sv
// Module: rx_desc_engine (top)
// Walks a list of receive descriptors in shared memory: it fetches the four
// descriptor words, parks on a descriptor software still holds, packs frame
// bytes into the buffer and writes status back before moving on.
// Assumes: one read outstanding at a time, read data returns on mem_rvalid
// after the grant; buffer addresses are word aligned; one frame per
// descriptor.
module rx_desc_engine #(
    parameter int AW    = 32,
    parameter int BSZ_W = 11,
    parameter int LEN_W = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic [AW-1:0] list_base,
    input  logic          poll_demand,
    input  logic          fr_valid,
    input  logic [7:0]    fr_data,
    input  logic          fr_last,
    input  logic          fr_err,
    output logic          fr_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata
);
    import rxd_pkg::*;

    localparam logic [1:0] IDX_LAST = 2'd3;

    rxd_state_e       state_q;
    logic [AW-1:0]    cur_q;
    logic [AW-1:0]    buf_q;
    logic [AW-1:0]    nxt_q;
    logic [BSZ_W-1:0] size_q;
    logic             chain_q;
    logic             eor_q;
    logic [1:0]       idx_q;

    logic             pk_clr;
    logic             pk_active;
    logic             pk_wr_valid;
    logic [BSZ_W:0]   pk_off;
    logic [31:0]      pk_data;
    logic [3:0]       pk_be;
    logic             pk_ack;
    logic             pk_done;
    logic [LEN_W-1:0] pk_len;
    logic             pk_bad;
    logic [31:0]      status_word;
    logic [AW-1:0]    next_addr;

    // Packer control derived from the walk state.
    always_comb begin
        pk_clr    = (state_q == ST_RD_WAIT) && mem_rvalid && (idx_q == IDX_LAST);
        pk_active = (state_q == ST_RECV);
        pk_ack    = (state_q == ST_RECV) && mem_gnt;
    end

    rxd_packer #(
        .BSZ_W(BSZ_W),
        .LEN_W(LEN_W)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pk_clr),
        .active    (pk_active),
        .buf_size  (size_q),
        .in_valid  (fr_valid),
        .in_data   (fr_data),
        .in_last   (fr_last),
        .in_err    (fr_err),
        .in_ready  (fr_ready),
        .wr_valid  (pk_wr_valid),
        .wr_off    (pk_off),
        .wr_data   (pk_data),
        .wr_be     (pk_be),
        .wr_ack    (pk_ack),
        .done      (pk_done),
        .frame_len (pk_len),
        .frame_bad (pk_bad)
    );

    rxd_status_fmt #(
        .LEN_W(LEN_W)
    ) u_status (
        .frame_len   (pk_len),
        .frame_bad   (pk_bad),
        .status_word (status_word)
    );

    rxd_next_sel #(
        .AW(AW)
    ) u_next (
        .cur_addr   (cur_q),
        .base_addr  (list_base),
        .chain_addr (nxt_q),
        .chain_en   (chain_q),
        .ring_end   (eor_q),
        .next_addr  (next_addr)
    );

    // Memory port mux: descriptor reads, buffer writes, status write-back.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        mem_be    = '0;
        case (state_q)
            ST_RD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({idx_q, 2'b00});
                mem_be   = 4'hf;
            end
            ST_RECV: begin
                mem_req   = pk_wr_valid;
                mem_we    = 1'b1;
                mem_addr  = buf_q + AW'(pk_off);
                mem_wdata = pk_data;
                mem_be    = pk_be;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = status_word;
                mem_be    = 4'hf;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // Descriptor walk state machine and captured descriptor fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cur_q   <= '0;
            buf_q   <= '0;
            nxt_q   <= '0;
            size_q  <= '0;
            chain_q <= 1'b0;
            eor_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    if (rx_enable) begin
                        cur_q   <= list_base;
                        idx_q   <= '0;
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_gnt) begin
                        state_q <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        case (idx_q)
                            2'd0: begin
                                if (mem_rdata[OWN_BIT]) begin
                                    idx_q   <= 2'd1;
                                    state_q <= ST_RD_REQ;
                                end else begin
                                    state_q <= ST_PARK;
                                end
                            end
                            2'd1: begin
                                size_q  <= mem_rdata[BSZ_W-1:0];
                                chain_q <= mem_rdata[CHAIN_BIT];
                                eor_q   <= mem_rdata[EOR_BIT];
                                idx_q   <= 2'd2;
                                state_q <= ST_RD_REQ;
                            end
                            2'd2: begin
                                buf_q   <= mem_rdata[AW-1:0];
                                idx_q   <= 2'd3;
                                state_q <= ST_RD_REQ;
                            end
                            default: begin
                                nxt_q   <= mem_rdata[AW-1:0];
                                state_q <= ST_RECV;
                            end
                        endcase
                    end
                end
                ST_PARK: begin
                    if (!rx_enable) begin
                        state_q <= ST_OFF;
                    end else if (poll_demand) begin
                        idx_q   <= '0;
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_RECV: begin
                    if (pk_done) begin
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (mem_gnt) begin
                        cur_q   <= next_addr;
                        idx_q   <= '0;
                        state_q <= rx_enable ? ST_RD_REQ : ST_OFF;
                    end
                end
                default: begin
                    state_q <= ST_OFF;
                end
            endcase
        end
    end

    // R8: an ungranted request is held with the same address and direction.
    p_hold_until_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: a parked engine is silent on both memory and frame sides.
    p_parked_is_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK) |-> (!mem_req && !fr_ready));

    // R1: while off, nothing moves.
    p_off_is_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!mem_req && !fr_ready));

    // R6: the full-word write-back returns ownership and marks first/last.
    p_writeback_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB && mem_req) |->
            (!mem_wdata[OWN_BIT] && mem_wdata[FIRST_BIT] && mem_wdata[LAST_BIT]));

    // R6: the status write never overlaps a pending data word.
    p_status_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB) |-> !pk_wr_valid);

endmodule

// File: tb/rx_desc_engine_test.sv
`timescale 1ns/1ps
module rx_desc_engine_test;

    localparam int AW = 32;

    // Vector fields: [7:0] length, [15:8] buffer size, [16] error,
    // [17] throttled grant, [18] poll pulse during reception.
    localparam int NVEC = 8;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0000_4008,
        32'h0002_400D,
        32'h0001_4001,
        32'h0006_0A14,
        32'h0000_0404,
        32'h0002_4040,
        32'h0000_0007,
        32'h0005_0506
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_enable = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          poll_demand = 1'b0;
    logic          fr_valid = 1'b0;
    logic [7:0]    fr_data = '0;
    logic          fr_last = 1'b0;
    logic          fr_err = 1'b0;
    logic          fr_ready;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          mem_gnt;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;

    logic [31:0]   mem [256];
    int            cyc = 0;
    logic          slow_gnt = 1'b0;
    int            rd_cnt = 0;
    logic [31:0]   last_rd = '0;
    logic [31:0]   rd_log [8];
    int            hold_err = 0;
    logic          p_req = 1'b0;
    logic          p_gnt = 1'b0;
    logic [31:0]   p_addr = '0;
    logic          p_we = 1'b0;
    int            total = 0;
    int            fails = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;
    assign mem_gnt = slow_gnt ? ((cyc % 3) == 0) : 1'b1;

    // Memory model and request-hold monitor.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && p_req && !p_gnt) begin
            if (!mem_req || mem_addr != p_addr || mem_we != p_we) hold_err = hold_err + 1;
        end
        p_req  <= mem_req && rst_n;
        p_gnt  <= mem_gnt;
        p_addr <= mem_addr;
        p_we   <= mem_we;
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++) begin
                    if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                end
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
                rd_log[rd_cnt % 8] = mem_addr;
                last_rd = mem_addr;
                rd_cnt  = rd_cnt + 1;
            end
        end
    end

    rx_desc_engine #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .list_base(list_base),
        .poll_demand(poll_demand), .fr_valid(fr_valid), .fr_data(fr_data),
        .fr_last(fr_last), .fr_err(fr_err), .fr_ready(fr_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int v);
        return 8'((k * 5 + v * 17 + 1) & 8'hff);
    endfunction

    function automatic logic [7:0] rbyte(input int addr);
        return mem[addr >> 2][(addr % 4) * 8 +: 8];
    endfunction

    task automatic pulse_poll();
        @(negedge clk) poll_demand = 1'b1;
        @(negedge clk) poll_demand = 1'b0;
    endtask

    task automatic send_frame(input int v, input int len, input bit err, input bit pm);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            fr_valid = 1'b1;
            fr_data  = pat(k, v);
            fr_last  = (k == len - 1);
            fr_err   = err;
            poll_demand = pm && (k == 2);
            forever begin
                automatic logic r = fr_ready;
                @(posedge clk);
                @(negedge clk);
                if (r) break;
            end
            poll_demand = 1'b0;
            fr_valid = 1'b0;
            fr_last  = 1'b0;
            fr_err   = 1'b0;
        end
    endtask

    task automatic wait_status(input int addr);
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (!mem[addr >> 2][31]) break;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic set_desc(input int at, input logic [31:0] ctl,
                            input logic [31:0] bufa, input logic [31:0] nxt);
        mem[(at >> 2) + 1] = ctl;
        mem[(at >> 2) + 2] = bufa;
        mem[(at >> 2) + 3] = nxt;
        mem[at >> 2]       = 32'h8000_0000;
    endtask

    // Directed next-address case: one short frame, then read the fetch target.
    task automatic next_case(input string req, input int at, input logic [31:0] ctl,
                             input logic [31:0] nxt, input logic [31:0] exp_next);
        int c0;
        set_desc(at, ctl, 32'h0000_0200, nxt);
        pulse_poll();
        send_frame(9, 4, 1'b0, 1'b0);
        c0 = rd_cnt;
        wait_status(at);
        chk(last_rd == exp_next && rd_cnt - c0 == 1, req, "next descriptor fetch", last_rd, exp_next);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hEEEE_EEEE;
        for (int i = 64; i < 80; i++) mem[i] = 32'h0;

        repeat (4) @(negedge clk);
        chk(!mem_req && !fr_ready, "R1", "quiet in reset", {30'd0, mem_req, fr_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!mem_req && !fr_ready && rd_cnt == 0, "R1", "quiet while disabled",
            rd_cnt, 32'd0);

        list_base = 32'h100;
        rx_enable = 1'b1;
        repeat (30) @(negedge clk);
        chk(rd_cnt == 1 && last_rd == 32'h100, "R2", "first fetch at base", last_rd, 32'h100);
        chk(!mem_req && !fr_ready, "R3", "parked on software-owned descriptor",
            {30'd0, mem_req, fr_ready}, 32'd0);

        // Table-driven frames into a self-chained descriptor at the base.
        for (int i = 0; i < NVEC; i++) begin
            automatic logic [31:0] v = VEC[i];
            automatic int  len  = int'(v[7:0]);
            automatic int  bsz  = int'(v[15:8]);
            automatic bit  err  = v[16];
            automatic bit  pm   = v[18];
            automatic int  kept = (len < bsz) ? len : bsz;
            automatic bit  es   = err || (len > bsz);
            automatic logic [31:0] exp_st;
            automatic int  c0, c1, bad_data, bad_keep;
            slow_gnt = v[17];
            for (int w = 128; w < 160; w++) mem[w] = 32'hEEEE_EEEE;
            set_desc(32'h100, 32'h0100_0000 | 32'(bsz), 32'h200, 32'h100);
            c0 = rd_cnt;
            pulse_poll();
            send_frame(i, len, err, pm);
            c1 = rd_cnt;
            wait_status(32'h100);
            if (i == 0) begin
                automatic bit ord = 1'b1;
                for (int k = 0; k < 4; k++)
                    if (rd_log[(c0 + k) % 8] != 32'h100 + 32'(4 * k)) ord = 1'b0;
                chk(ord, "R2", "descriptor word read order", rd_log[(c0 + 1) % 8], 32'h104);
            end
            exp_st = 32'h4000_0100 | (32'(len) << 16) | (32'(es) << 15);
            chk(mem[64] == exp_st, (len > bsz) ? "R5" : "R6", "status word", mem[64], exp_st);
            bad_data = 0;
            for (int k = 0; k < kept; k++)
                if (rbyte(32'h200 + k) != pat(k, i)) bad_data++;
            chk(bad_data == 0, "R4", "buffer bytes", 32'(bad_data), 32'd0);
            bad_keep = 0;
            for (int k = kept; k < 80; k++)
                if (rbyte(32'h200 + k) != 8'hEE) bad_keep++;
            chk(bad_keep == 0, "R5", "bytes past limit untouched", 32'(bad_keep), 32'd0);
            chk(rd_cnt - c1 == 1 && last_rd == 32'h100, pm ? "R9" : "R7",
                "single refetch via chain pointer", 32'(rd_cnt - c1), 32'd1);
        end
        slow_gnt = 1'b0;

        // R7: sequential, end-of-ring, and chain-over-ring priority.
        mem[68] = 32'h0;
        next_case("R7", 32'h100, 32'h0000_0040, 32'h0000_0300, 32'h110);
        next_case("R7", 32'h110, 32'h0200_0040, 32'h0000_0120, 32'h100);
        mem[72] = 32'h0;
        next_case("R7", 32'h100, 32'h0300_0040, 32'h0000_0120, 32'h120);

        // R10: disable while parked, poll ignored, re-enable reloads base.
        begin
            automatic int c0 = rd_cnt;
            automatic int busy = 0;
            rx_enable = 1'b0;
            repeat (3) @(negedge clk);
            pulse_poll();
            for (int n = 0; n < 20; n++) begin
                @(negedge clk);
                if (mem_req || fr_ready) busy++;
            end
            chk(busy == 0 && rd_cnt == c0, "R10", "poll ignored while off", 32'(busy), 32'd0);
            list_base = 32'h110;
            rx_enable = 1'b1;
            repeat (20) @(negedge clk);
            chk(rd_cnt - c0 == 1 && last_rd == 32'h110, "R10", "restart at new base",
                last_rd, 32'h110);
        end

        chk(hold_err == 0, "R8", "ungranted request held", 32'(hold_err), 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        fails = fails + 1;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule